// File: doc/BRIEF.md
# Boot Handshake Sequencer

This block runs the byte-level conversation of a serial boot session. After a fixed number of leading bytes, which it does not interpret, it takes one byte as a baud-rate selection code. It looks that code up in a table indexed by the configured operating frequency. A code the table supports is echoed back, and the new baud divisor is applied only once the echo has left the transmitter. A code the table does not support causes a single rate-error byte to be sent, and the session then halts.

Once the rate is settled, the block hands reception to an external hex loader. It watches every byte the loader writes to RAM, adding each one into a 16-bit wraparound sum and latching the first write address. When the loader reports a clean end record, the block transmits the sum, upper byte first. It then waits for a start command. A correct command is echoed, after which the block raises a jump request carrying the latched entry address and the initial stack pointer. A wrong command, or a receive error at that point, causes the command-error byte to be sent three times before the block halts. A loader fault halts the block without sending anything.

Top module: `boot_handshake_seq`

## Requirements
- R1: The first HDR_BYTES (7) received bytes are ignored whatever their value or error flag. No byte is transmitted in response to them, and the next received byte is taken as the selection code.
- R2: A supported selection code is transmitted back unchanged. `baud_div` keeps its old value while that echo is in flight and takes the table divisor only after `tx_busy` has fallen.
- R3: The selection table for the default configuration is as follows. Codes 28H, 18H, 0CH, 06H and 03H map to divisors 0100H, 0080H, 0040H, 0020H and (none) at frequency 0, and to 0200H, 0100H, 0080H, 0040H and 0020H at frequency 1. A divisor of zero marks a code as unsupported. Code 28H occupies slot 0, and its divisor is the reset value of `baud_div`.
- R4: An unsupported or unknown selection code, or one received with `rx_err`, causes exactly one 62H byte to be sent. After that, nothing more is transmitted and `ldr_en` stays low.
- R5: `ldr_en` is high from the baud change until the loader reports done or fault. A fault ends the session with no byte sent.
- R6: After `ldr_done`, the block sends the 16-bit wraparound sum of all bytes written by the loader, upper byte first and then lower byte.
- R7: A start command C0H received without error is echoed. After the echo, `jump_req` goes high and stays high, `stack_ptr` reads 4A000H, and `jump_addr` equals the address of the first loader write.
- R8: Any other command byte, or any byte with `rx_err`, at the command stage causes CMD_ERR_CODE (63H) to be sent three times in a row. The block then halts with `jump_req` low.
- R9: `tx_start` is pulsed only while `tx_busy` is low, and once per transmitted byte.
- R10: After reset, `tx_start`, `ldr_en` and `jump_req` are low, `stack_ptr` is 0 and `baud_div` is 0100H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| rx_err | input | 1 | Framing or parity error on the strobed byte |
| tx_data | output | 8 | Byte to transmit |
| tx_start | output | 1 | One-cycle transmit request |
| tx_busy | input | 1 | Transmitter busy; rises the cycle after tx_start |
| baud_div | output | DIV_W | Current baud divisor |
| ldr_en | output | 1 | Hex loader owns reception |
| ldr_wr | input | 1 | Loader RAM write strobe |
| ldr_addr | input | ADDR_W | Loader RAM write address |
| ldr_wdata | input | 8 | Loader RAM write byte |
| ldr_done | input | 1 | Loader saw a clean end record |
| ldr_fault | input | 1 | Loader saw a receive or checksum error |
| jump_req | output | 1 | Request to start the user program |
| jump_addr | output | ADDR_W | Entry address (first loader write) |
| stack_ptr | output | SP_W | Initial stack pointer, valid with jump_req |

## Verification
The bench sweeps every selection code at frequency 0, plus one unknown code. A design that swapped the divisor at the moment of the echo request would show the new value while the transmitter is still busy. A design that accepted the unsupported 03H entry would echo it instead of sending 62H. Loads of 300 bytes of FFH force the sum past 16 bits, so a design that sent the bytes in the wrong order or kept a wider sum is caught. The bench also checks for a wrong command, a correct command flagged with a receive error, and a loader fault. These catch a design that miscounts the error repeats, jumps on a flagged byte, or keeps talking after a fault.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [3:0] {
        ST_HDR,
        ST_SEL,
        ST_BAUD,
        ST_LOAD,
        ST_SUM_LO,
        ST_CMD,
        ST_ERR,
        ST_TX_ISSUE,
        ST_TX_WAIT,
        ST_JUMP,
        ST_HALT
    } seq_state_e;

endpackage

// File: rtl/baud_decode.sv
module baud_decode #(
    parameter int NUM_CODES = 5,
    parameter int DIV_W     = 16,
    parameter logic [NUM_CODES*8-1:0]     SEL_CODES = '0,
    parameter logic [NUM_CODES*DIV_W-1:0] DIV_ROW   = '0
) (
    input  logic [7:0]       code,
    output logic             sel_ok,
    output logic [DIV_W-1:0] sel_div
);

    logic [NUM_CODES-1:0] hit;
    logic [DIV_W-1:0]     masked [NUM_CODES];

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_slot
        assign hit[i]    = (code == SEL_CODES[i*8 +: 8]);
        assign masked[i] = hit[i] ? DIV_ROW[i*DIV_W +: DIV_W] : '0;
    end

    always_comb begin
        sel_div = '0;
        for (int i = 0; i < NUM_CODES; i++) begin
            sel_div = sel_div | masked[i];
        end
        sel_ok = (|hit) && (sel_div != '0);
    end

endmodule

// File: rtl/load_sum.sv
module load_sum #(
    parameter int ADDR_W = 24,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [SUM_W-1:0]  sum,
    output logic [ADDR_W-1:0] first_addr
);

    typedef struct packed {
        logic [SUM_W-1:0]  acc;
        logic [ADDR_W-1:0] first;
        logic              seen;
    } sum_reg_t;

    sum_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.acc = r_q.acc + SUM_W'(wr_data);
            if (!r_q.seen) begin
                r_d.first = wr_addr;
                r_d.seen  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sum        = r_q.acc;
    assign first_addr = r_q.first;

    p_first_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.seen |=> $stable(r_q.first));

endmodule

// File: rtl/boot_handshake_seq.sv
module boot_handshake_seq
    import boot_seq_pkg::*;
#(
    parameter int HDR_BYTES  = 7,
    parameter int DIV_W      = 16,
    parameter int ADDR_W     = 24,
    parameter int SP_W       = 20,
    parameter int NUM_CODES  = 5,
    parameter int NUM_FREQ   = 2,
    parameter int FREQ_SEL   = 0,
    parameter int ERR_REPEAT = 3,
    parameter logic [NUM_CODES*8-1:0] SEL_CODES =
        {8'h03, 8'h06, 8'h0C, 8'h18, 8'h28},
    parameter logic [NUM_FREQ*NUM_CODES*DIV_W-1:0] DIV_TABLE =
        {16'h0020, 16'h0040, 16'h0080, 16'h0100, 16'h0200,
         16'h0000, 16'h0020, 16'h0040, 16'h0080, 16'h0100},
    parameter logic [7:0] BAD_SEL_CODE = 8'h62,
    parameter logic [7:0] START_CMD    = 8'hC0,
    parameter logic [7:0] CMD_ERR_CODE = 8'h63,
    parameter logic [SP_W-1:0] SP_INIT = 20'h4A000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_err,
    output logic [7:0]        tx_data,
    output logic              tx_start,
    input  logic              tx_busy,
    output logic [DIV_W-1:0]  baud_div,
    output logic              ldr_en,
    input  logic              ldr_wr,
    input  logic [ADDR_W-1:0] ldr_addr,
    input  logic [7:0]        ldr_wdata,
    input  logic              ldr_done,
    input  logic              ldr_fault,
    output logic              jump_req,
    output logic [ADDR_W-1:0] jump_addr,
    output logic [SP_W-1:0]   stack_ptr
);

    localparam int SUM_W    = 16;
    localparam int HCW      = $clog2(HDR_BYTES + 1);
    localparam int ECW      = $clog2(ERR_REPEAT + 1);
    localparam int ROW_W    = NUM_CODES * DIV_W;
    localparam logic [ROW_W-1:0] DIV_ROW = DIV_TABLE[FREQ_SEL*ROW_W +: ROW_W];
    localparam logic [DIV_W-1:0] INIT_DIV = DIV_ROW[0 +: DIV_W];

    typedef struct packed {
        seq_state_e       st;
        seq_state_e       ret;
        logic [7:0]       tx_q;
        logic [HCW-1:0]   hdr_cnt;
        logic [ECW-1:0]   err_cnt;
        logic [DIV_W-1:0] div_pend;
        logic [DIV_W-1:0] div_q;
        logic             jump_q;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    logic             sel_ok;
    logic [DIV_W-1:0] sel_div;
    logic [SUM_W-1:0] sum;
    logic [ADDR_W-1:0] first_addr;

    baud_decode #(
        .NUM_CODES (NUM_CODES),
        .DIV_W     (DIV_W),
        .SEL_CODES (SEL_CODES),
        .DIV_ROW   (DIV_ROW)
    ) u_decode (
        .code    (rx_data),
        .sel_ok  (sel_ok),
        .sel_div (sel_div)
    );

    load_sum #(
        .ADDR_W (ADDR_W),
        .SUM_W  (SUM_W)
    ) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ldr_en && ldr_wr),
        .wr_addr    (ldr_addr),
        .wr_data    (ldr_wdata),
        .sum        (sum),
        .first_addr (first_addr)
    );

    always_comb begin
        s_d      = s_q;
        tx_start = 1'b0;
        ldr_en   = 1'b0;
        unique case (s_q.st)
            ST_HDR: begin
                if (rx_valid) begin
                    if (s_q.hdr_cnt == HCW'(HDR_BYTES - 1)) s_d.st = ST_SEL;
                    else s_d.hdr_cnt = s_q.hdr_cnt + 1'b1;
                end
            end
            ST_SEL: begin
                if (rx_valid) begin
                    s_d.st = ST_TX_ISSUE;
                    if (!rx_err && sel_ok) begin
                        s_d.tx_q     = rx_data;
                        s_d.div_pend = sel_div;
                        s_d.ret      = ST_BAUD;
                    end else begin
                        s_d.tx_q = BAD_SEL_CODE;
                        s_d.ret  = ST_HALT;
                    end
                end
            end
            ST_BAUD: begin
                s_d.div_q = s_q.div_pend;
                s_d.st    = ST_LOAD;
            end
            ST_LOAD: begin
                ldr_en = 1'b1;
                if (ldr_fault) begin
                    s_d.st = ST_HALT;
                end else if (ldr_done) begin
                    s_d.tx_q = sum[SUM_W-1 -: 8];
                    s_d.ret  = ST_SUM_LO;
                    s_d.st   = ST_TX_ISSUE;
                end
            end
            ST_SUM_LO: begin
                s_d.tx_q = sum[7:0];
                s_d.ret  = ST_CMD;
                s_d.st   = ST_TX_ISSUE;
            end
            ST_CMD: begin
                if (rx_valid) begin
                    if (!rx_err && rx_data == START_CMD) begin
                        s_d.tx_q = START_CMD;
                        s_d.ret  = ST_JUMP;
                        s_d.st   = ST_TX_ISSUE;
                    end else begin
                        s_d.err_cnt = '0;
                        s_d.st      = ST_ERR;
                    end
                end
            end
            ST_ERR: begin
                s_d.tx_q    = CMD_ERR_CODE;
                s_d.err_cnt = s_q.err_cnt + 1'b1;
                s_d.ret     = (s_q.err_cnt == ECW'(ERR_REPEAT - 1)) ? ST_HALT : ST_ERR;
                s_d.st      = ST_TX_ISSUE;
            end
            ST_TX_ISSUE: begin
                if (!tx_busy) begin
                    tx_start = 1'b1;
                    s_d.st   = ST_TX_WAIT;
                end
            end
            ST_TX_WAIT: begin
                if (!tx_busy) s_d.st = s_q.ret;
            end
            ST_JUMP: begin
                s_d.jump_q = 1'b1;
            end
            ST_HALT: begin
                s_d.st = ST_HALT;
            end
            default: s_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= ST_HDR;
            s_q.ret      <= ST_HALT;
            s_q.tx_q     <= '0;
            s_q.hdr_cnt  <= '0;
            s_q.err_cnt  <= '0;
            s_q.div_pend <= INIT_DIV;
            s_q.div_q    <= INIT_DIV;
            s_q.jump_q   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_data   = s_q.tx_q;
    assign baud_div  = s_q.div_q;
    assign jump_req  = s_q.jump_q;
    assign jump_addr = first_addr;
    assign stack_ptr = s_q.jump_q ? SP_INIT : '0;

    p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);

    p_div_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(baud_div));

    p_jump_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> jump_req);

    p_jump_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> (stack_ptr == SP_INIT));

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HALT) |-> (!tx_start && !ldr_en && !jump_req));

    p_load_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ldr_en |-> !tx_start);

endmodule

// File: tb/boot_handshake_seq_test.sv
module boot_handshake_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_err = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_start;
    logic        tx_busy = 1'b0;
    logic [15:0] baud_div;
    logic        ldr_en;
    logic        ldr_wr = 1'b0;
    logic [23:0] ldr_addr = '0;
    logic [7:0]  ldr_wdata = '0;
    logic        ldr_done = 1'b0, ldr_fault = 1'b0;
    logic        jump_req;
    logic [23:0] jump_addr;
    logic [19:0] stack_ptr;

    int checks = 0, failures = 0;
    logic [7:0] txlog [0:31];
    int ntx = 0;
    int bcnt = 0;
    int busy_viol = 0;
    int exp_sum;

    localparam logic [7:0]  CODES [5] = '{8'h28, 8'h18, 8'h0C, 8'h06, 8'h03};
    localparam logic [15:0] DIVS0 [5] = '{16'h0100, 16'h0080, 16'h0040, 16'h0020, 16'h0000};

    always #10 clk = ~clk;

    boot_handshake_seq uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err),
        .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy), .baud_div(baud_div),
        .ldr_en(ldr_en), .ldr_wr(ldr_wr), .ldr_addr(ldr_addr), .ldr_wdata(ldr_wdata),
        .ldr_done(ldr_done), .ldr_fault(ldr_fault), .jump_req(jump_req),
        .jump_addr(jump_addr), .stack_ptr(stack_ptr)
    );

    // transmitter model: busy from the cycle after start for 4 cycles
    always @(posedge clk) begin
        if (tx_start) begin
            if (tx_busy) busy_viol <= busy_viol + 1;
            if (ntx < 32) txlog[ntx] <= tx_data;
            ntx     <= ntx + 1;
            tx_busy <= 1'b1;
            bcnt    <= 4;
        end else if (bcnt != 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) tx_busy <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        @(posedge clk);
        ntx = 0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit err);
        @(negedge clk);
        rx_data = b; rx_err = err; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_err = 1'b0;
        idle(2);
    endtask

    task automatic wait_tx(input int n, input string req);
        int t = 0;
        while (ntx < n && t < 2000) begin @(negedge clk); t++; end
        check(ntx >= n, req, ntx, n);
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (tx_busy && t < 2000) begin @(negedge clk); t++; end
        idle(4);
    endtask

    task automatic header();
        // header bytes include command and code values plus an error flag
        send_rx(8'hC0, 1'b0); send_rx(8'h28, 1'b0); send_rx(8'h3A, 1'b1);
        send_rx(8'h00, 1'b0); send_rx(8'hFF, 1'b0); send_rx(8'h18, 1'b0);
        send_rx(8'h62, 1'b0);
        idle(10);
        check(ntx == 0, "R1 header ignored", ntx, 0);
    endtask

    task automatic load_bytes(input int n, input int kind, input logic [23:0] base);
        exp_sum = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = (kind == 0) ? 8'hFF : 8'((i * 13 + 7) & 255);
            @(negedge clk);
            ldr_wr = 1'b1; ldr_addr = base + 24'(i); ldr_wdata = v;
            exp_sum = (exp_sum + int'(v)) & 16'hFFFF;
            @(negedge clk);
            ldr_wr = 1'b0;
        end
        @(negedge clk); ldr_done = 1'b1;
        @(negedge clk); ldr_done = 1'b0;
    endtask

    // start a session with code 18H and run the load; returns with sum sent
    task automatic session_to_cmd(input int n, input int kind, input logic [23:0] base);
        do_reset();
        header();
        send_rx(8'h18, 1'b0);
        wait_tx(1, "R2 echo 18");
        wait_idle();
        check(ldr_en == 1'b1, "R5 loader enabled", ldr_en, 1);
        load_bytes(n, kind, base);
        wait_tx(3, "R6 sum bytes");
        check(txlog[1] == 8'(exp_sum >> 8), "R6 sum upper first", txlog[1], exp_sum >> 8);
        check(txlog[2] == 8'(exp_sum), "R6 sum lower second", txlog[2], exp_sum & 255);
        check(ldr_en == 1'b0, "R5 loader released", ldr_en, 0);
        wait_idle();
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 reset state
        idle(2);
        check(tx_start == 0 && ldr_en == 0 && jump_req == 0, "R10 reset outputs", {tx_start, ldr_en, jump_req}, 0);
        check(stack_ptr == 0, "R10 reset stack_ptr", stack_ptr, 0);
        check(baud_div == 16'h0100, "R10 reset baud_div", baud_div, 16'h0100);

        // R2 R3 R4 sweep over every selection code at frequency 0
        for (int c = 0; c < 5; c++) begin
            do_reset();
            header();
            send_rx(CODES[c], 1'b0);
            wait_tx(1, "R3 one reply");
            if (DIVS0[c] != 0) begin
                check(txlog[0] == CODES[c], "R2 echo value", txlog[0], CODES[c]);
                check(tx_busy && baud_div == 16'h0100, "R2 divisor held during echo", baud_div, 16'h0100);
                wait_idle();
                check(baud_div == DIVS0[c], "R3 divisor after echo", baud_div, DIVS0[c]);
                check(ldr_en == 1'b1, "R5 load stage", ldr_en, 1);
            end else begin
                check(txlog[0] == 8'h62, "R4 unsupported code", txlog[0], 8'h62);
                idle(60);
                check(ntx == 1 && ldr_en == 0, "R4 halted", ntx, 1);
                check(baud_div == 16'h0100, "R4 divisor unchanged", baud_div, 16'h0100);
            end
        end

        // R4 unknown code and flagged code
        do_reset(); header(); send_rx(8'h55, 1'b0);
        wait_tx(1, "R4 unknown reply");
        check(txlog[0] == 8'h62, "R4 unknown code", txlog[0], 8'h62);
        idle(60);
        check(ntx == 1 && ldr_en == 0, "R4 halt after unknown", ntx, 1);
        do_reset(); header(); send_rx(8'h28, 1'b1);
        wait_tx(1, "R4 flagged reply");
        check(txlog[0] == 8'h62, "R4 flagged code", txlog[0], 8'h62);

        // R6 R7 full session with wrapping sum
        session_to_cmd(300, 0, 24'h01_2340);
        check(jump_req == 0, "R7 no jump before command", jump_req, 0);
        send_rx(8'hC0, 1'b0);
        wait_tx(4, "R7 echo");
        check(txlog[3] == 8'hC0, "R7 echo value", txlog[3], 8'hC0);
        wait_idle();
        check(jump_req == 1, "R7 jump raised", jump_req, 1);
        check(stack_ptr == 20'h4A000, "R7 stack pointer", stack_ptr, 20'h4A000);
        check(jump_addr == 24'h01_2340, "R7 entry address", jump_addr, 24'h01_2340);
        idle(20);
        check(jump_req == 1 && ntx == 4, "R7 jump held", ntx, 4);

        // R8 wrong command
        session_to_cmd(20, 1, 24'h00_8000);
        send_rx(8'hC1, 1'b0);
        wait_tx(6, "R8 error bytes");
        wait_idle(); idle(60);
        check(ntx == 6, "R8 exactly three", ntx, 6);
        check(txlog[3] == 8'h63 && txlog[4] == 8'h63 && txlog[5] == 8'h63, "R8 error code", txlog[4], 8'h63);
        check(jump_req == 0, "R8 no jump", jump_req, 0);

        // R8 correct byte with receive error
        session_to_cmd(5, 1, 24'h00_0010);
        send_rx(8'hC0, 1'b1);
        wait_tx(6, "R8 flagged command");
        wait_idle(); idle(60);
        check(ntx == 6 && txlog[5] == 8'h63, "R8 flagged gives three errors", ntx, 6);
        check(jump_req == 0, "R8 flagged no jump", jump_req, 0);

        // R5 loader fault
        do_reset(); header(); send_rx(8'h0C, 1'b0);
        wait_tx(1, "R5 echo before fault"); wait_idle();
        @(negedge clk); ldr_fault = 1'b1;
        @(negedge clk); ldr_fault = 1'b0;
        idle(60);
        check(ntx == 1 && ldr_en == 0, "R5 fault silent halt", ntx, 1);
        send_rx(8'hC0, 1'b0); idle(30);
        check(ntx == 1 && jump_req == 0, "R5 halted ignores input", ntx, 1);

        check(busy_viol == 0, "R9 start while busy", busy_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule